// File: doc/BRIEF.md
# Tachometer Speed Discriminator with Phase Detector and Lock Flag

This block closes the digital half of a motor speed servo. A tachometer pulse train from the motor arrives on an asynchronous input. The block synchronises it and picks out its rising edges. It then measures the time between consecutive rising edges in units of a prescaled clock. The prescaled clock is the system (crystal) clock divided by `PRESCALE`. The servo target is one tachometer period of `TARGET` prescaled ticks, so the commanded tachometer frequency is the crystal frequency divided by `PRESCALE*TARGET`. With the defaults of 16 and 512, that ratio is 8192.

Three digital outputs feed the external analog loop filter:

- **Frequency discriminator output.** Updated once per pair of tachometer periods. It goes high when the motor runs too fast.
- **Phase detector pulse pair.** A reference divider emits one event every `TARGET` ticks. The detector compares these events with every tachometer edge and raises either an "up" or a "down" request.
- **Active-low lock flag.** Driven low when the measured speed is within ±1/16 (6.25 %) of the target.

A stop control holds all measuring and comparing logic in its idle state. A stalled motor saturates the period counter and is reported as unlocked.

Top module: `fgs_speed_servo`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `disc_fast`, `phase_up` and `phase_dn` are 0 and `lock_n` is 1.
- R2: A measured period is the number of prescale ticks (one tick every `PRESCALE` clocks while running) between two consecutive synchronised rising edges. A tick in the same clock as the closing edge counts toward the closing period. The first edge after reset or after stop only opens a measurement.
- R3: `disc_fast` and `lock_n` change only after a measurement pair completes, a stall, stop or reset. A pair is two consecutive measured periods evaluated on their sum, so an exact sum of `2*TARGET` is not overspeed.
- R4: `disc_fast` is 1 when the sum of a period pair is less than `2*TARGET`, and 0 otherwise.
- R5: `lock_n` is 0 when the pair sum lies in the inclusive window `[2*TARGET-2*TOL, 2*TARGET+2*TOL]`, with `TOL = TARGET/16`, and 1 outside it.
- R6: A reference divider emits an event every `TARGET` ticks. The phase detector raises `phase_up` on a reference event and `phase_dn` on a tachometer edge. Both clear when the opposite event arrives or when both events arrive together, so the two outputs are never 1 together.
- R7: When the period counter reaches its all-ones maximum without an edge, the next clock forces `lock_n` to 1 and `disc_fast` to 0, and the pending pair is discarded.
- R8: While `stop` is 1, the outputs hold the reset values from the clock after `stop` is sampled high, and tachometer edges have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived system clock |
| rst | input | 1 | Synchronous active-high reset |
| stop | input | 1 | 1 = stop (hold idle), 0 = run |
| fg_in | input | 1 | Asynchronous tachometer pulse input |
| disc_fast | output | 1 | Frequency discriminator result, 1 = overspeed |
| phase_up | output | 1 | Phase detector request to raise drive |
| phase_dn | output | 1 | Phase detector request to lower drive |
| lock_n | output | 1 | 0 = speed within the ±6.25 % window |

## Verification
The checker watches every cycle for these properties:

- The phase requests are mutually exclusive.
- The discriminator and lock outputs move only after a completed pair, a stall, stop or reset.
- A stall pulse always leaves the lock flag released.
- Stop forces the idle values.

Only the bench scenarios can show the numeric behaviour. This covers the exact window boundaries (60/68 ticks locked, 59/69 unlocked, 63 ticks fast, 64 ticks not fast) and the stall timeout. It also covers which phase request dominates for a fast or slow motor, which the bench compares clock by clock against its behavioural model.

// File: rtl/fgs_pkg.sv
package fgs_pkg;
  localparam int unsigned DEF_PRESCALE = 16;
  localparam int unsigned DEF_TARGET   = 512;

  typedef enum logic [1:0] {
    PD_IDLE = 2'b00,
    PD_UP   = 2'b01,
    PD_DN   = 2'b10
  } pd_state_t;
endpackage

// File: rtl/fgs_edge_sync.sv
module fgs_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/fgs_tick_gen.sv
module fgs_tick_gen #(
  parameter int unsigned PRESCALE = 16,
  parameter int unsigned TARGET   = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick,
  output logic ref_pulse
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int unsigned RW = (TARGET > 1) ? $clog2(TARGET) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(PRESCALE - 1);
  localparam logic [RW-1:0] R_LAST = RW'(TARGET - 1);

  logic [PW-1:0] pcnt;
  logic [RW-1:0] rcnt;

  assign tick      = run && (pcnt == P_LAST);
  assign ref_pulse = tick && (rcnt == R_LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt <= '0;
      rcnt <= '0;
    end else begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
      if (tick) rcnt <= (rcnt == R_LAST) ? '0 : rcnt + 1'b1;
    end
  end
endmodule

// File: rtl/fgs_period_meter.sv
module fgs_period_meter #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             rise,
  output logic             meas_vld,
  output logic [CNT_W-1:0] meas_val,
  output logic             stall_p
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] per;
  logic             primed;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      per      <= '0;
      primed   <= 1'b0;
      meas_vld <= 1'b0;
      meas_val <= '0;
      stall_p  <= 1'b0;
    end else begin
      meas_vld <= 1'b0;
      stall_p  <= 1'b0;
      if (rise) begin
        if (primed) begin
          meas_vld <= 1'b1;
          meas_val <= (tick && per != MAXV) ? per + 1'b1 : per;
        end
        per    <= '0;
        primed <= 1'b1;
      end else if (tick && per != MAXV) begin
        per     <= per + 1'b1;
        stall_p <= (per == MAXV - 1'b1);
      end
    end
  end
endmodule

// File: rtl/fgs_discriminator.sv
module fgs_discriminator #(
  parameter int unsigned TARGET = 512,
  parameter int unsigned TOL    = 32,
  parameter int unsigned CNT_W  = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             meas_vld,
  input  logic [CNT_W-1:0] meas_val,
  input  logic             stall_p,
  output logic             disc_fast,
  output logic             lock_n
);
  localparam int unsigned SUM_W = CNT_W + 1;
  localparam logic [SUM_W-1:0] NOM = SUM_W'(2 * TARGET);
  localparam logic [SUM_W-1:0] LO  = SUM_W'(2 * TARGET - 2 * TOL);
  localparam logic [SUM_W-1:0] HI  = SUM_W'(2 * TARGET + 2 * TOL);

  logic             pair;
  logic [CNT_W-1:0] first;
  logic [SUM_W-1:0] sum;

  assign sum = {1'b0, first} + {1'b0, meas_val};

  always_ff @(posedge clk) begin
    if (rst || !run || stall_p) begin
      pair      <= 1'b0;
      first     <= '0;
      disc_fast <= 1'b0;
      lock_n    <= 1'b1;
    end else if (meas_vld) begin
      if (!pair) begin
        first <= meas_val;
        pair  <= 1'b1;
      end else begin
        pair      <= 1'b0;
        disc_fast <= (sum < NOM);
        lock_n    <= !((sum >= LO) && (sum <= HI));
      end
    end
  end
endmodule

// File: rtl/fgs_phase_cmp.sv
module fgs_phase_cmp
  import fgs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic ref_pulse,
  input  logic rise,
  output logic phase_up,
  output logic phase_dn
);
  pd_state_t st, st_nx;
  logic want_up, want_dn;

  always_comb begin
    want_up = (st == PD_UP) || ref_pulse;
    want_dn = (st == PD_DN) || rise;
    if (want_up && want_dn) st_nx = PD_IDLE;
    else if (want_up)       st_nx = PD_UP;
    else if (want_dn)       st_nx = PD_DN;
    else                    st_nx = PD_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) st <= PD_IDLE;
    else             st <= st_nx;
  end

  assign phase_up = (st == PD_UP);
  assign phase_dn = (st == PD_DN);
endmodule

// File: rtl/fgs_speed_servo.sv
module fgs_speed_servo #(
  parameter int unsigned PRESCALE    = fgs_pkg::DEF_PRESCALE,
  parameter int unsigned TARGET      = fgs_pkg::DEF_TARGET,
  parameter int unsigned TOL         = TARGET / 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = $clog2(TARGET) + 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stop,
  input  logic fg_in,
  output logic disc_fast,
  output logic phase_up,
  output logic phase_dn,
  output logic lock_n
);
  logic             run;
  logic             rise_raw, rise;
  logic             tick, ref_pulse;
  logic             meas_vld, stall_p;
  logic [CNT_W-1:0] meas_val;

  assign run  = !stop;
  assign rise = rise_raw && run;

  fgs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(fg_in), .rise(rise_raw)
  );

  fgs_tick_gen #(.PRESCALE(PRESCALE), .TARGET(TARGET)) u_tick (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .ref_pulse(ref_pulse)
  );

  fgs_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .rise(rise),
    .meas_vld(meas_vld), .meas_val(meas_val), .stall_p(stall_p)
  );

  fgs_discriminator #(.TARGET(TARGET), .TOL(TOL), .CNT_W(CNT_W)) u_disc (
    .clk(clk), .rst(rst), .run(run), .meas_vld(meas_vld),
    .meas_val(meas_val), .stall_p(stall_p),
    .disc_fast(disc_fast), .lock_n(lock_n)
  );

  fgs_phase_cmp u_pfd (
    .clk(clk), .rst(rst), .run(run), .ref_pulse(ref_pulse), .rise(rise),
    .phase_up(phase_up), .phase_dn(phase_dn)
  );
endmodule

// File: rtl/fgs_servo_checker.sv
module fgs_servo_checker (
  input logic clk,
  input logic rst,
  input logic stop,
  input logic disc_fast,
  input logic phase_up,
  input logic phase_dn,
  input logic lock_n,
  input logic meas_vld,
  input logic stall_p
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (lock_n && !disc_fast && !phase_up && !phase_dn)); // R1

  AST_LOCK_EVENT: assert property (@(posedge clk) disable iff (rst)
    !$stable(lock_n) |-> ($past(meas_vld) || $past(stall_p) || $past(stop))); // R3

  AST_DISC_EVENT: assert property (@(posedge clk) disable iff (rst)
    !$stable(disc_fast) |-> ($past(meas_vld) || $past(stall_p) || $past(stop))); // R4

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(phase_up && phase_dn)); // R6

  AST_STALL_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    stall_p |=> (lock_n && !disc_fast)); // R7

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    stop |=> (lock_n && !disc_fast && !phase_up && !phase_dn)); // R8
endmodule

bind fgs_speed_servo fgs_servo_checker u_chk (
  .clk(clk), .rst(rst), .stop(stop), .disc_fast(disc_fast),
  .phase_up(phase_up), .phase_dn(phase_dn), .lock_n(lock_n),
  .meas_vld(meas_vld), .stall_p(stall_p)
);

// File: tb/fgs_speed_servo_test.sv
`timescale 1ns/1ps
module fgs_speed_servo_test;
  localparam int P   = 4;
  localparam int T   = 64;
  localparam int L   = T / 16;
  localparam int MAX = 255;

  logic clk = 0, rst = 1, stop = 1, fg_in = 0;
  logic disc_fast, phase_up, phase_dn, lock_n;
  int checks = 0, fails = 0, up_seen = 0, dn_seen = 0;

  always #4 clk = ~clk;

  fgs_speed_servo #(.PRESCALE(P), .TARGET(T)) uut (
    .clk(clk), .rst(rst), .stop(stop), .fg_in(fg_in),
    .disc_fast(disc_fast), .phase_up(phase_up), .phase_dn(phase_dn), .lock_n(lock_n)
  );

  // behavioural reference model
  int s1, s2, s3, pc, rc, per, primed, mv, mval, mst, pair, first;
  int fast, lkn, up, dn;
  always @(posedge clk) begin
    int e, tk, rf, nu, nd, sum;
    if (rst) begin
      s1 = 0; s2 = 0; s3 = 0; pc = 0; rc = 0; per = 0; primed = 0;
      mv = 0; mval = 0; mst = 0; pair = 0; first = 0;
      fast = 0; lkn = 1; up = 0; dn = 0;
    end else begin
      e = (s2 && !s3) ? 1 : 0;
      s3 = s2; s2 = s1; s1 = fg_in;
      if (stop || mst) begin
        fast = 0; lkn = 1; pair = 0;
      end else if (mv) begin
        if (!pair) begin first = mval; pair = 1; end
        else begin
          sum = first + mval; pair = 0;
          fast = (sum < 2*T) ? 1 : 0;
          lkn = (sum >= 2*T - 2*L && sum <= 2*T + 2*L) ? 0 : 1;
        end
      end
      if (stop) begin
        pc = 0; rc = 0; per = 0; primed = 0; mv = 0; mst = 0; up = 0; dn = 0;
      end else begin
        tk = (pc == P-1) ? 1 : 0;
        pc = tk ? 0 : pc + 1;
        rf = (tk && rc == T-1) ? 1 : 0;
        if (tk) rc = (rc == T-1) ? 0 : rc + 1;
        mv = 0; mst = 0;
        if (e) begin
          if (primed) begin mv = 1; mval = (per + tk > MAX) ? MAX : per + tk; end
          per = 0; primed = 1;
        end else if (tk && per < MAX) begin
          per = per + 1;
          if (per == MAX) mst = 1;
        end
        nu = (up || rf) ? 1 : 0;
        nd = (dn || e) ? 1 : 0;
        if (nu && nd) begin up = 0; dn = 0; end
        else begin up = nu; dn = nd; end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // clock-by-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R4 disc_fast vs model", disc_fast, fast);
      chk("R5 lock_n vs model", lock_n, lkn);
      chk("R6 phase_up vs model", phase_up, up);
      chk("R6 phase_dn vs model", phase_dn, dn);
      if (phase_up) up_seen++;
      if (phase_dn) dn_seen++;
    end
  end

  task automatic fg_run(int period, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) fg_in = 1;
      repeat (period/2) @(negedge clk);
      fg_in = 0;
      repeat (period - period/2 - 1) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset lock_n", lock_n, 1);
    chk("R1 reset disc_fast", disc_fast, 0);
    chk("R1 reset phase", phase_up | phase_dn, 0);
    rst = 0; stop = 0;
    fg_run(256, 12);
    chk("R3 exact target not fast", disc_fast, 0);
    chk("R5 exact target locked", lock_n, 0);
    fg_run(252, 8);
    chk("R4 63 ticks fast", disc_fast, 1);
    chk("R5 63 ticks locked", lock_n, 0);
    fg_run(240, 8);
    chk("R5 low edge 60 ticks locked", lock_n, 0);
    chk("R2 60 ticks fast", disc_fast, 1);
    fg_run(236, 8);
    chk("R5 59 ticks unlocked", lock_n, 1);
    fg_run(272, 8);
    chk("R5 high edge 68 ticks locked", lock_n, 0);
    chk("R4 68 ticks not fast", disc_fast, 0);
    fg_run(276, 8);
    chk("R5 69 ticks unlocked", lock_n, 1);
    up_seen = 0; dn_seen = 0;
    fg_run(200, 10);
    chk("R4 fast motor", disc_fast, 1);
    chk("R6 fast motor lowers drive", (dn_seen > up_seen) ? 1 : 0, 1);
    up_seen = 0; dn_seen = 0;
    fg_run(320, 8);
    chk("R6 slow motor raises drive", (up_seen > dn_seen) ? 1 : 0, 1);
    fg_run(256, 8);
    chk("R5 relock", lock_n, 0);
    fg_in = 0;
    repeat (1200) @(negedge clk);
    chk("R7 stall unlocked", lock_n, 1);
    chk("R7 stall not fast", disc_fast, 0);
    fg_run(256, 8);
    chk("R7 recovery locks", lock_n, 0);
    fg_run(200, 4);
    stop = 1;
    repeat (2) @(negedge clk);
    chk("R8 stop lock_n", lock_n, 1);
    chk("R8 stop disc_fast", disc_fast, 0);
    fg_run(200, 6);
    chk("R8 edges ignored lock_n", lock_n, 1);
    chk("R8 edges ignored disc", disc_fast, 0);
    chk("R8 edges ignored phase", phase_up | phase_dn, 0);
    stop = 0;
    fg_run(256, 8);
    chk("R2 restart after stop", lock_n, 0);
    rst = 1;
    repeat (2) @(negedge clk);
    chk("R1 mid-run reset", lock_n, 1);
    finish_run();
  end
endmodule